// File: doc/BRIEF.md
# NAND Page Transfer and Interrupt Controller

This block is the control core of a simple NAND flash controller. Software programs it through a small word-addressed register window. It holds the flash configuration bits (chip-enable override, ECC enables, burst, direction and bus width) and drives them out to the pin-timing and ECC blocks. It also reports the flash ready line and the occupancy of the two data FIFOs.

A page transfer works like this. Software loads a byte count and sets the start bit. The data path then reports each byte it moves with a one-cycle strobe, and the count steps down by one per strobe. When the count runs out, the block raises a transfer-count event. A rising edge on the synchronised ready/busy pin raises a ready event. Both events are kept in a raw interrupt register with separate enable, set and write-one-to-clear access. The interrupt output is asserted while any enabled event is pending.

A soft reset bit in the control register clears every register and aborts a transfer in flight.

Top module: `nand_page_ctl`

## Requirements
- R1: After the asynchronous reset, every readable register returns 0, and `irq`, `xfer_req`, `ecc_clr` and all configuration outputs are low.
- R2: Configuration register, at address 1. Bit 0 is the bus width (`bus_wide`) and bit 1 the direction (`dir_read`, 1 = read). Bit 2 is burst (`burst_en`), bit 3 ECC enable (`ecc_en`), bit 4 ECC to DMA path (`ecc_to_dma`) and bit 5 the chip-enable override (`ce_force_low`). It reads back these six bits, and higher written bits read 0.
- R3: Status register, at address 2. It reads bit 0 = synchronised ready level, bit 1 = `cpu_fifo_busy` and bit 2 = `xfer_fifo_busy`.
- R4: Count register, at address 7. A write loads the count. Each `byte_stb` cycle lowers it by one, but only while start (control bit 0, address 0) is set and the count is nonzero. Strobes without start, or at zero, leave it unchanged.
- R5: When a strobe takes the count from 1 to 0 while start is set, raw interrupt bit 1 (transfer count) is set.
- R6: Raw interrupt bit 0 (ready) is set on a 0-to-1 change of `flash_rdy` after a two-flop synchroniser. It appears three clock edges after the pin changes. A falling edge sets nothing.
- R7: `irq` is high exactly when raw status (address 3) AND enable (address 4) is nonzero.
- R8: Writing the set register (address 5) ORs the written bits 1:0 into raw status.
- R9: Writing the clear register (address 6) clears the raw bits written as 1 and leaves the others. Writing 3 clears both. An event arriving in the same cycle as a clear stays set.
- R10: Writing control bit 2 clears control, configuration, enable, raw status and count at the next edge. The bit always reads 0, and a transfer in progress stops.
- R11: Writing control bit 1 gives a single-cycle `ecc_clr` pulse in the cycle after the write. The bit reads 0.
- R12: `xfer_req` is high exactly while start is set and the count is nonzero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 3 | Register word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` |
| byte_stb | input | 1 | One data byte moved this cycle |
| xfer_fifo_busy | input | 1 | Transfer FIFO holds data |
| cpu_fifo_busy | input | 1 | CPU FIFO holds data |
| flash_rdy | input | 1 | Flash ready/busy pin (asynchronous) |
| irq | output | 1 | Interrupt request |
| xfer_req | output | 1 | Transfer enabled and bytes remain |
| ecc_clr | output | 1 | One-cycle ECC accumulator clear |
| ce_force_low | output | 1 | Chip enable held active |
| ecc_to_dma | output | 1 | ECC result routed to DMA path |
| ecc_en | output | 1 | ECC calculation enabled |
| burst_en | output | 1 | Burst transfers |
| dir_read | output | 1 | Transfer direction, 1 = from flash |
| bus_wide | output | 1 | External bus width, 1 = 16-bit |

## Verification
Two situations are hard to reach from the ports. The first is the same-cycle race between the last byte strobe and a software clear of the interrupt. The bench drives both in one cycle and expects the event to survive. The second is the count running out under a random mix of loads, start toggles and strobes. A bench model tracks that sequence, so the zero boundary, strobes past zero and strobes without start all occur many times. The ready edge is checked both before and after it passes the synchroniser, so the check pins down its exact latency.

// File: rtl/nand_ctl_pkg.sv
package nand_ctl_pkg;

  localparam int REG_AW = 3;

  typedef enum logic [REG_AW-1:0] {
    RA_CTRL    = 3'd0,
    RA_CFG     = 3'd1,
    RA_STAT    = 3'd2,
    RA_IRQ_RAW = 3'd3,
    RA_IRQ_EN  = 3'd4,
    RA_IRQ_SET = 3'd5,
    RA_IRQ_CLR = 3'd6,
    RA_COUNT   = 3'd7
  } reg_addr_e;

  // control register bits
  localparam int CTRL_START  = 0;
  localparam int CTRL_ECCCLR = 1;
  localparam int CTRL_SRST   = 2;

  // interrupt bits (shared by raw, enable, set, clear)
  localparam int IRQ_W   = 2;
  localparam int IRQ_RDY = 0;
  localparam int IRQ_TC  = 1;

  // configuration, packed MSB first so the bit index matches the register
  typedef struct packed {
    logic ce_low;    // bit 5
    logic ecc_dma;   // bit 4
    logic ecc_on;    // bit 3
    logic burst;     // bit 2
    logic dir_rd;    // bit 1
    logic wide;      // bit 0
  } cfg_t;

  localparam int CFG_W = $bits(cfg_t);
  localparam int STAT_W = 3;

endpackage

// File: rtl/nand_rdy_sync.sv
module nand_rdy_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rdy_i,
  output logic lvl_o,
  output logic rise_o
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;
  logic              prev_q;

  for (genvar gi = 0; gi < STAGES; gi++) begin : g_stage
    if (gi == 0) begin : g_first
      assign chain_d[gi] = rdy_i;
    end else begin : g_next
      assign chain_d[gi] = chain_q[gi-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
      prev_q  <= 1'b0;
    end else begin
      chain_q <= chain_d;
      prev_q  <= chain_q[STAGES-1];
    end
  end

  assign lvl_o  = chain_q[STAGES-1];
  assign rise_o = chain_q[STAGES-1] & ~prev_q;

  AST_RDY_ONESHOT: assert property (@(posedge clk) disable iff (!rst_n)
    rise_o |=> !rise_o); // R6

endmodule

// File: rtl/nand_xfer_cnt.sv
module nand_xfer_cnt #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_i,
  input  logic             ld_i,
  input  logic [CNT_W-1:0] ld_val_i,
  input  logic             start_i,
  input  logic             byte_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             tc_o,
  output logic             busy_o
);

  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             cnt_en;
  logic             nonzero;
  logic             step;

  always_comb begin
    nonzero = (cnt_q != '0);
    step    = start_i & byte_i & nonzero & ~ld_i & ~clr_i;
    tc_o    = step & (cnt_q == CNT_ONE);
    cnt_en  = clr_i | ld_i | step;
    if (clr_i) begin
      cnt_d = '0;
    end else if (ld_i) begin
      cnt_d = ld_val_i;
    end else begin
      cnt_d = cnt_q - CNT_ONE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign cnt_o  = cnt_q;
  assign busy_o = start_i & nonzero;

  AST_CNT_NO_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    !ld_i |=> (cnt_q <= $past(cnt_q))); // R4

  AST_TC_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    tc_o |=> (cnt_q == '0)); // R5

endmodule

// File: rtl/nand_irq_regs.sv
module nand_irq_regs #(
  parameter int IRQ_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_all_i,
  input  logic [IRQ_W-1:0] evt_i,
  input  logic             set_we_i,
  input  logic             clr_we_i,
  input  logic             en_we_i,
  input  logic [IRQ_W-1:0] wbits_i,
  output logic [IRQ_W-1:0] raw_o,
  output logic [IRQ_W-1:0] en_o,
  output logic             irq_o
);

  logic [IRQ_W-1:0] raw_q, raw_d;
  logic [IRQ_W-1:0] en_q, en_d;
  logic [IRQ_W-1:0] set_bits, clr_bits;

  always_comb begin
    set_bits = set_we_i ? wbits_i : '0;
    clr_bits = clr_we_i ? wbits_i : '0;
    if (clr_all_i) begin
      raw_d = '0;
      en_d  = '0;
    end else begin
      raw_d = (raw_q & ~clr_bits) | evt_i | set_bits;
      en_d  = en_we_i ? wbits_i : en_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      raw_q <= '0;
      en_q  <= '0;
    end else begin
      raw_q <= raw_d;
      if (en_we_i || clr_all_i) begin
        en_q <= en_d;
      end
    end
  end

  assign raw_o = raw_q;
  assign en_o  = en_q;
  assign irq_o = |(raw_q & en_q);

  AST_CLR_ALL: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_we_i && (&wbits_i) && !(|evt_i) && !clr_all_i) |=> (raw_q == '0)); // R9

  AST_EVT_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    ((|evt_i) && !clr_all_i) |=> ((raw_q & $past(evt_i)) == $past(evt_i))); // R9

endmodule

// File: rtl/nand_page_ctl.sv
module nand_page_ctl
  import nand_ctl_pkg::*;
#(
  parameter int DATA_W      = 32,
  parameter int CNT_W       = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_we,
  input  logic [REG_AW-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              byte_stb,
  input  logic              xfer_fifo_busy,
  input  logic              cpu_fifo_busy,
  input  logic              flash_rdy,
  output logic              irq,
  output logic              xfer_req,
  output logic              ecc_clr,
  output logic              ce_force_low,
  output logic              ecc_to_dma,
  output logic              ecc_en,
  output logic              burst_en,
  output logic              dir_read,
  output logic              bus_wide
);

  // write decode
  logic wr_ctrl, wr_cfg, wr_en, wr_set, wr_clr, wr_cnt, srst;

  always_comb begin
    wr_ctrl = bus_we && (bus_addr == RA_CTRL);
    wr_cfg  = bus_we && (bus_addr == RA_CFG);
    wr_en   = bus_we && (bus_addr == RA_IRQ_EN);
    wr_set  = bus_we && (bus_addr == RA_IRQ_SET);
    wr_clr  = bus_we && (bus_addr == RA_IRQ_CLR);
    wr_cnt  = bus_we && (bus_addr == RA_COUNT);
    srst    = wr_ctrl && bus_wdata[CTRL_SRST];
  end

  // control and configuration registers
  logic start_q, start_d;
  cfg_t cfg_q, cfg_d;
  logic ecc_clr_q, ecc_clr_d;
  logic ctl_en;

  always_comb begin
    ctl_en    = wr_ctrl | wr_cfg;
    start_d   = start_q;
    cfg_d     = cfg_q;
    ecc_clr_d = wr_ctrl && bus_wdata[CTRL_ECCCLR] && !srst;
    if (srst) begin
      start_d = 1'b0;
      cfg_d   = '0;
    end else begin
      if (wr_ctrl) start_d = bus_wdata[CTRL_START];
      if (wr_cfg)  cfg_d   = cfg_t'(bus_wdata[CFG_W-1:0]);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      start_q   <= 1'b0;
      cfg_q     <= '0;
      ecc_clr_q <= 1'b0;
    end else begin
      if (ctl_en) begin
        start_q <= start_d;
        cfg_q   <= cfg_d;
      end
      ecc_clr_q <= ecc_clr_d;
    end
  end

  // ready pin synchroniser and edge detector
  logic rdy_lvl, rdy_rise;

  nand_rdy_sync #(.STAGES(SYNC_STAGES)) u_rdy (
    .clk    (clk),
    .rst_n  (rst_n),
    .rdy_i  (flash_rdy),
    .lvl_o  (rdy_lvl),
    .rise_o (rdy_rise)
  );

  // transfer counter
  logic [CNT_W-1:0] cnt_w;
  logic             tc_evt;
  logic             busy_w;

  nand_xfer_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr_i    (srst),
    .ld_i     (wr_cnt),
    .ld_val_i (bus_wdata[CNT_W-1:0]),
    .start_i  (start_q),
    .byte_i   (byte_stb),
    .cnt_o    (cnt_w),
    .tc_o     (tc_evt),
    .busy_o   (busy_w)
  );

  // interrupt registers
  logic [IRQ_W-1:0] evt_w, irq_raw, irq_en;

  always_comb begin
    evt_w          = '0;
    evt_w[IRQ_TC]  = tc_evt;
    evt_w[IRQ_RDY] = rdy_rise;
  end

  nand_irq_regs #(.IRQ_W(IRQ_W)) u_irq (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr_all_i (srst),
    .evt_i     (evt_w),
    .set_we_i  (wr_set),
    .clr_we_i  (wr_clr),
    .en_we_i   (wr_en),
    .wbits_i   (bus_wdata[IRQ_W-1:0]),
    .raw_o     (irq_raw),
    .en_o      (irq_en),
    .irq_o     (irq)
  );

  // read path
  always_comb begin
    bus_rdata = '0;
    unique case (bus_addr)
      RA_CTRL:    bus_rdata[CTRL_START] = start_q;
      RA_CFG:     bus_rdata[CFG_W-1:0]  = cfg_q;
      RA_STAT:    bus_rdata[STAT_W-1:0] = {xfer_fifo_busy, cpu_fifo_busy, rdy_lvl};
      RA_IRQ_RAW: bus_rdata[IRQ_W-1:0]  = irq_raw;
      RA_IRQ_EN:  bus_rdata[IRQ_W-1:0]  = irq_en;
      RA_COUNT:   bus_rdata[CNT_W-1:0]  = cnt_w;
      default:    bus_rdata = '0;
    endcase
  end

  assign xfer_req     = busy_w;
  assign ecc_clr      = ecc_clr_q;
  assign ce_force_low = cfg_q.ce_low;
  assign ecc_to_dma   = cfg_q.ecc_dma;
  assign ecc_en       = cfg_q.ecc_on;
  assign burst_en     = cfg_q.burst;
  assign dir_read     = cfg_q.dir_rd;
  assign bus_wide     = cfg_q.wide;

  AST_SRST_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    srst |=> (cfg_q == '0 && !start_q && cnt_w == '0 && irq_raw == '0 && irq_en == '0)); // R10

  AST_REQ_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
    srst |=> !xfer_req); // R10

endmodule

// File: tb/nand_page_ctl_test.sv
module nand_page_ctl_test;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus_we;
  logic [2:0]  bus_addr;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic        byte_stb, xfer_fifo_busy, cpu_fifo_busy, flash_rdy;
  logic        irq, xfer_req, ecc_clr;
  logic        ce_force_low, ecc_to_dma, ecc_en, burst_en, dir_read, bus_wide;

  int tests = 0;
  int fails = 0;
  bit done  = 1'b0;

  always #4 clk = ~clk;

  nand_page_ctl uut (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .byte_stb(byte_stb),
    .xfer_fifo_busy(xfer_fifo_busy), .cpu_fifo_busy(cpu_fifo_busy),
    .flash_rdy(flash_rdy), .irq(irq), .xfer_req(xfer_req), .ecc_clr(ecc_clr),
    .ce_force_low(ce_force_low), .ecc_to_dma(ecc_to_dma), .ecc_en(ecc_en),
    .burst_en(burst_en), .dir_read(dir_read), .bus_wide(bus_wide)
  );

  function automatic logic exp_irq(logic [1:0] raw, logic [1:0] en);
    return |(raw & en);
  endfunction

  function automatic logic exp_req(logic st, int cnt);
    return st && (cnt != 0);
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // write one register; returns just after the following falling edge
  task automatic wr(logic [2:0] a, logic [31:0] d);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(logic [2:0] a, output logic [31:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic strobe(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); byte_stb = 1'b1;
      @(negedge clk); byte_stb = 1'b0;
    end
  endtask

  function automatic logic [31:0] pins();
    return {26'd0, ce_force_low, ecc_to_dma, ecc_en, burst_en, dir_read, bus_wide};
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    int m_cnt;
    logic m_start;
    logic m_tc;
    rst_n = 1'b0; bus_we = 1'b0; bus_addr = '0; bus_wdata = '0;
    byte_stb = 1'b0; xfer_fifo_busy = 1'b0; cpu_fifo_busy = 1'b0; flash_rdy = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    for (int a = 0; a < 8; a++) begin
      rd(3'(a), v); chk("R1 reg", v, 32'd0);
    end
    chk("R1 pins", {irq, xfer_req, ecc_clr, pins()[5:0]}, 32'd0);

    // R2 configuration bits
    for (int b = 0; b < 6; b++) begin
      wr(3'd1, 32'd1 << b);
      rd(3'd1, v); chk("R2 readback", v, 32'd1 << b);
      chk("R2 pins", pins(), 32'd1 << b);
    end
    wr(3'd1, 32'hFFFF_FFEA);
    rd(3'd1, v); chk("R2 masked", v, 32'h2A);
    wr(3'd1, 32'd0);

    // R3 status bits
    xfer_fifo_busy = 1'b1; rd(3'd2, v); chk("R3 xfer fifo", v, 32'd4);
    xfer_fifo_busy = 1'b0; cpu_fifo_busy = 1'b1; rd(3'd2, v); chk("R3 cpu fifo", v, 32'd2);
    cpu_fifo_busy = 1'b0;

    // R4 count ignored without start
    wr(3'd7, 32'd5);
    strobe(3);
    rd(3'd7, v); chk("R4 no start", v, 32'd5);
    chk("R12 idle", {31'd0, xfer_req}, 32'd0);
    wr(3'd0, 32'd1);
    chk("R12 active", {31'd0, xfer_req}, 32'd1);
    for (int k = 4; k >= 0; k--) begin
      strobe(1);
      rd(3'd7, v); chk("R4 step", v, 32'(k));
    end
    rd(3'd3, v); chk("R5 tc event", v, 32'd2);
    chk("R12 done", {31'd0, xfer_req}, 32'd0);
    strobe(2);
    rd(3'd7, v); chk("R4 hold zero", v, 32'd0);

    // R7 masking
    chk("R7 masked", {31'd0, irq}, 32'd0);
    wr(3'd4, 32'd2);
    chk("R7 enabled", {31'd0, irq}, 32'd1);
    // R9 partial clear
    wr(3'd6, 32'd1);
    rd(3'd3, v); chk("R9 other bit kept", v, 32'd2);
    wr(3'd6, 32'd3);
    rd(3'd3, v); chk("R9 clear all", v, 32'd0);
    chk("R7 after clear", {31'd0, irq}, 32'd0);

    // R8 set register
    wr(3'd5, 32'd1);
    rd(3'd3, v); chk("R8 set", v, 32'd1);
    chk("R7 set masked", {31'd0, irq}, 32'd0);
    wr(3'd4, 32'd3);
    chk("R8 irq", {31'd0, irq}, 32'd1);
    wr(3'd6, 32'd3);

    // R6 ready edge latency
    @(negedge clk); flash_rdy = 1'b1;
    @(negedge clk); @(negedge clk);
    rd(3'd3, v); chk("R6 not yet", v, 32'd0);
    rd(3'd2, v); chk("R3 ready level", v, 32'd1);
    @(negedge clk);
    rd(3'd3, v); chk("R6 latched", v, 32'd1);
    wr(3'd6, 32'd3);
    flash_rdy = 1'b0;
    repeat (4) @(negedge clk);
    rd(3'd3, v); chk("R6 falling ignored", v, 32'd0);

    // R11 ECC clear pulse
    @(negedge clk);
    bus_we = 1'b1; bus_addr = 3'd0; bus_wdata = 32'd2;
    @(negedge clk); bus_we = 1'b0;
    chk("R11 pulse", {31'd0, ecc_clr}, 32'd1);
    @(negedge clk);
    chk("R11 one cycle", {31'd0, ecc_clr}, 32'd0);
    rd(3'd0, v); chk("R11 reads zero", v, 32'd0);

    // R9 event beats a same-cycle clear
    wr(3'd7, 32'd1);
    wr(3'd0, 32'd1);
    @(negedge clk);
    byte_stb = 1'b1; bus_we = 1'b1; bus_addr = 3'd6; bus_wdata = 32'd3;
    @(negedge clk);
    byte_stb = 1'b0; bus_we = 1'b0;
    rd(3'd3, v); chk("R9 event wins", v, 32'd2);

    // R10 soft reset
    wr(3'd1, 32'h3F);
    wr(3'd7, 32'd9);
    wr(3'd5, 32'd3);
    chk("R12 before reset", {31'd0, xfer_req}, 32'd1);
    wr(3'd0, 32'd7);
    for (int a = 0; a < 8; a++) begin
      rd(3'(a), v); chk("R10 reg cleared", v, 32'd0);
    end
    chk("R10 pins", {irq, xfer_req, pins()[5:0]}, 32'd0);
    strobe(1);
    rd(3'd7, v); chk("R10 aborted", v, 32'd0);

    // random mix against a model
    void'($urandom(32'h5EED_0001));
    wr(3'd4, 32'd2);
    m_cnt = 0; m_start = 1'b0; m_tc = 1'b0;
    for (int it = 0; it < 300; it++) begin
      int op;
      op = $urandom_range(0, 9);
      if (op == 0) begin
        int n;
        n = $urandom_range(0, 12);
        wr(3'd7, 32'(n)); m_cnt = n;
      end else if (op == 1) begin
        m_start = 1'($urandom_range(0, 1));
        wr(3'd0, {31'd0, m_start});
      end else if (op == 2) begin
        wr(3'd6, 32'd2); m_tc = 1'b0;
      end else begin
        strobe(1);
        if (m_start && m_cnt != 0) begin
          m_cnt--;
          if (m_cnt == 0) m_tc = 1'b1;
        end
      end
      rd(3'd7, v); chk("R4 random count", v, 32'(m_cnt));
      rd(3'd3, v); chk("R5 random tc", v, {30'd0, m_tc, 1'b0});
      chk("R7 random irq", {31'd0, irq}, {31'd0, exp_irq({m_tc, 1'b0}, 2'b10)});
      chk("R12 random req", {31'd0, xfer_req}, {31'd0, exp_req(m_start, m_cnt)});
    end

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule